// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block sits behind a serial word receiver. Each incoming 16-bit word holds two consecutive 8-bit converter samples. The controller watches the stream for a level event. An event is a word whose high byte reaches a fixed threshold. A programmable number of such events can be passed over before one is taken as the trigger. After the trigger, a second programmable count of words is thrown away. The controller then writes every following word into a buffer memory at consecutive addresses until the buffer is full, and raises a done flag.

The word input is a valid/ready stream. A word transfers only in a cycle where both `in_valid_i` and `in_ready_o` are high. The controller drives `in_ready_o` high while it is waiting for a trigger, skipping words or storing words. It drives it low while idle or done, so no word is consumed then. Inside the active states it never applies back-pressure. The memory write port has no handshake, because the memory takes one write per cycle. Upstream, each 8-bit sample is shifted out lowest bit first, with one frame pulse every 8 bit clocks, and the word assembly happens before this block.

Top module: `trig_capture`

## Requirements
- R1: After reset, `done_o`, `in_ready_o` and `mem_we_o` are all low and the controller is idle.
- R2: A `start_i` pulse in the idle or done state arms the controller. From the next cycle `in_ready_o` is high and `done_o` is low. A `start_i` pulse while arming, skipping or capturing has no effect on the stored result.
- R3: A word qualifies as an event exactly when bits 15:8 are greater than or equal to 240. Bits 7:0 take no part, and a high byte of 239 never qualifies.
- R4: With `trig_skip_i` = N, the first N qualifying transferred words are passed over and the (N+1)-th becomes the trigger. N = 0 takes the first qualifying word.
- R5: With `word_skip_i` = M, the M transferred words after the trigger are discarded. The trigger word itself is never stored. With M = 0, storing begins with the first transferred word after the trigger.
- R6: Stored words go to addresses 0, 1, 2 and onward in transfer order with unchanged data. Each word appears on `mem_we_o`/`mem_addr_o`/`mem_wdata_o` in the cycle after its transfer.
- R7: After exactly DEPTH writes the controller enters done. `done_o` stays high, `in_ready_o` stays low and no further write occurs until the next `start_i`.
- R8: A cycle with `in_valid_i` low changes no state and no counter, whatever `in_data_i` holds.
- R9: `in_ready_o` is high only in the arming, skipping and capturing states. Only words transferred under valid and ready are counted, tested or stored.
- R10: Both skip counts are sampled on the arming `start_i` pulse. Later changes to `trig_skip_i` or `word_skip_i` do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm pulse, acts in idle or done |
| trig_skip_i | input | CNT_W | Number of qualifying events to pass over |
| word_skip_i | input | CNT_W | Number of words to discard after the trigger |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Controller accepts words |
| in_data_i | input | DATA_W | Input word: two samples, high byte tested |
| mem_we_o | output | 1 | Buffer write enable |
| mem_addr_o | output | ADDR_W | Buffer write address |
| mem_wdata_o | output | DATA_W | Buffer write data |
| done_o | output | 1 | Buffer full, held until next start |

## Verification
The assertions assume that `start_i` is a pulse and that the skip counts never exceed the counter width. They also assume that a word is offered only through `in_valid_i`, so the value of `in_data_i` in an idle-valid cycle is arbitrary. The stimulus holds to this. It drives a word-valid pattern with a gap every fifth cycle and puts an all-ones word on the bus in those gaps, a value that would qualify if it were wrongly taken. It pulses start once mid-run and scrambles the skip inputs right after arming. Every combination of trigger and word skip from 0 to 3 is swept.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_SKIP = 3'd2,
    ST_CAP  = 3'd3,
    ST_DONE = 3'd4
  } cap_state_e;

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/cap_trig_qual.sv
module cap_trig_qual #(
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 8,
  parameter int THRESH   = 240
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              hit_o
);
  localparam logic [SAMPLE_W-1:0] THR_V = SAMPLE_W'(THRESH);

  logic [SAMPLE_W-1:0] hi_sample;
  assign hi_sample = word_i[DATA_W-1 -: SAMPLE_W];
  assign hit_o     = (hi_sample >= THR_V);
endmodule

// File: rtl/cap_skip_ctr.sv
module cap_skip_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));

  // R4 / R5: a counter is only ever stepped down while it holds a nonzero count
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/cap_wr_port.sv
module cap_wr_port #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              last_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= push_i;
      if (clear_i) begin
        ptr_q <= '0;
      end else if (push_i) begin
        mem_addr_o  <= ptr_q;
        mem_wdata_o <= data_i;
        ptr_q       <= last_o ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign last_o = (ptr_q == LAST_ADDR);

  // R6: every write strobe follows a push one cycle earlier
  p_write_follows_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(push_i));
  // R6: back-to-back writes land on consecutive addresses
  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i && mem_we_o && !last_o) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic in_valid_i,
  input  logic hit_i,
  input  logic trig_zero_i,
  input  logic skip_zero_i,
  input  logic skip_last_i,
  input  logic buf_last_i,
  output logic in_ready_o,
  output logic load_o,
  output logic trig_dec_o,
  output logic skip_dec_o,
  output logic push_o,
  output logic done_o
);
  cap_state_e state_q, state_d;
  logic       acc;

  assign in_ready_o = (state_q == ST_ARM) || (state_q == ST_SKIP) || (state_q == ST_CAP);
  assign acc        = in_valid_i && in_ready_o;
  assign done_o     = (state_q == ST_DONE);

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    trig_dec_o = 1'b0;
    skip_dec_o = 1'b0;
    push_o     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_ARM;
        end
      end
      ST_ARM: begin
        if (acc && hit_i) begin
          if (trig_zero_i) state_d = skip_zero_i ? ST_CAP : ST_SKIP;
          else             trig_dec_o = 1'b1;
        end
      end
      ST_SKIP: begin
        if (acc) begin
          skip_dec_o = 1'b1;
          if (skip_last_i) state_d = ST_CAP;
        end
      end
      ST_CAP: begin
        if (acc) begin
          push_o = 1'b1;
          if (buf_last_i) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R2: start in idle or done arms the controller
  p_start_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state_q == ST_IDLE || state_q == ST_DONE)) |=> (in_ready_o && !done_o));
  // R8: an invalid cycle leaves the state untouched
  p_invalid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !start_i) |=> $stable(state_q));
  // R7: done is held until a start pulse
  p_done_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R4: a non-qualifying word never leaves the arming state
  p_arm_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !(acc && hit_i)) |=> (state_q == ST_ARM));
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 8,
  parameter int THRESH   = 240,
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 16,
  localparam int ADDR_W  = cap_pkg::addr_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  trig_skip_i,
  input  logic [CNT_W-1:0]  word_skip_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o
);
  logic hit, load, trig_dec, skip_dec, push;
  logic trig_zero, trig_last, skip_zero, skip_last, buf_last;

  cap_trig_qual #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) u_qual (
    .word_i(in_data_i), .hit_o(hit));

  cap_skip_ctr #(.CNT_W(CNT_W)) u_trig_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(trig_skip_i),
    .dec_i(trig_dec), .zero_o(trig_zero), .last_o(trig_last));

  cap_skip_ctr #(.CNT_W(CNT_W)) u_word_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(word_skip_i),
    .dec_i(skip_dec), .zero_o(skip_zero), .last_o(skip_last));

  cap_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .in_valid_i(in_valid_i),
    .hit_i(hit), .trig_zero_i(trig_zero), .skip_zero_i(skip_zero),
    .skip_last_i(skip_last), .buf_last_i(buf_last), .in_ready_o(in_ready_o),
    .load_o(load), .trig_dec_o(trig_dec), .skip_dec_o(skip_dec),
    .push_o(push), .done_o(done_o));

  cap_wr_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .push_i(push),
    .data_i(in_data_i), .last_o(buf_last), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  logic unused_last;
  assign unused_last = trig_last;

  // R7: no write once done has been seen for a full cycle
  p_no_write_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> !mem_we_o);
  // R9: a write only follows a transferred word
  p_write_needs_xfer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(in_valid_i && in_ready_o));
endmodule

// File: tb/test_trig_capture.sv
module test_trig_capture;
  localparam int DEPTH = 16;
  localparam int CNT_W = 16;
  localparam int AW    = 4;
  localparam int SLEN  = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] tskip = '0, wskip = '0;
  logic             vld = 1'b0;
  logic             rdy;
  logic [15:0]      din = '0;
  logic             we;
  logic [AW-1:0]    addr;
  logic [15:0]      wdata;
  logic             done;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  trig_capture #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_trig_capture (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trig_skip_i(tskip),
    .word_skip_i(wskip), .in_valid_i(vld), .in_ready_o(rdy), .in_data_i(din),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .done_o(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int r, input int k);
    bit q;
    logic [7:0] hi, lo;
    q  = ((k + r) % 4 == 0) || (k % 7 == 3);
    hi = q ? 8'(240 + (k % 16)) : 8'(239 - (k % 8));
    lo = 8'((k * 7 + r * 13) % 256);
    return {hi, lo};
  endfunction

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdy == 1'b0, "R1 ready", int'(rdy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(we == 1'b0, "R1 we", int'(we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle does not accept
    chk(rdy == 1'b0, "R9 idle ready", int'(rdy), 0);

    for (int ts = 0; ts < 4; ts++) begin
      for (int ws = 0; ws < 4; ws++) begin
        int r, p, nq, k, wc, step;
        logic [15:0] exp_w [DEPTH];
        logic [15:0] last_acc;
        r = ts * 4 + ws;
        // expected: position of the (ts+1)-th word with high byte >= 240 (R3, R4)
        nq = 0; p = -1;
        for (int j = 0; j < SLEN && p < 0; j++) begin
          if (word_of(r, j)[15:8] >= 8'd240) begin
            if (nq == ts) p = j;
            nq++;
          end
        end
        for (int i = 0; i < DEPTH; i++) exp_w[i] = word_of(r, p + 1 + ws + i); // R5

        start = 1'b1; tskip = CNT_W'(ts); wskip = CNT_W'(ws);
        @(negedge clk);
        start = 1'b0;
        tskip = 16'hA5A5; wskip = 16'h5A5A;  // R10: later changes ignored
        chk(rdy == 1'b1, "R2 armed ready", int'(rdy), 1);
        chk(done == 1'b0, "R2 done cleared", int'(done), 0);

        k = 0; wc = 0; step = 0; last_acc = '0;
        forever begin
          if (we) begin
            chk(int'(addr) == wc, "R6 address", int'(addr), wc);
            chk(wc < DEPTH && wdata == exp_w[wc], "R5 R10 data", int'(wdata),
                (wc < DEPTH) ? int'(exp_w[wc]) : -1);
            chk(wdata == last_acc, "R6 latency", int'(wdata), int'(last_acc));
            wc++;
          end
          if (done || step > 400) break;
          // R8: a gap cycle carries a word that would qualify
          if (step % 5 == 4) begin vld = 1'b0; din = 16'hFFFF; end
          else begin vld = 1'b1; din = word_of(r, k); end
          start = (step == 3);  // R2: ignored while active
          if (vld && rdy) begin last_acc = din; k++; end
          @(negedge clk);
          start = 1'b0;
          step++;
        end
        chk(wc == DEPTH, "R7 write count", wc, DEPTH);
        chk(done == 1'b1, "R7 done", int'(done), 1);
        chk(rdy == 1'b0, "R9 done ready", int'(rdy), 0);
        // R7: further qualifying words produce no write
        vld = 1'b1; din = 16'hF0F0;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk(we == 1'b0 && done == 1'b1, "R7 hold", int'(we), 0);
        end
        vld = 1'b0;
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule